// File: doc/BRIEF.md
# Multiplexed Detect Pulse Demultiplexer

This block produces a free-running select pulse for up to eight attached line-interface circuits and uses the same pulse to split one shared detector input per channel into two status bits. A line circuit routes one of two internal comparators to its single detect output, depending on the select level it receives. On the chip side, the block sends each synchronised detect pin to a primary status bit while the pulse is inactive. It sends the pin to an alternate status bit while the pulse is active. The bit that is not being fed keeps its last value.

The pulse is timed by a 64 kHz strobe that lasts one clock cycle. A cycle is thirteen strobe periods long, and the pulse is active for the first two of them. The mode runs only when both the multiplex enable and the clock-source qualifier are set. Otherwise the output-enable of the shared pin is dropped, so the pin can serve as an input. A polarity input sets the pin level for the active phase. It has no effect on the internal steering.

Top module: `dmx_detect_split`

## Requirements
- R1: The output-enable `sel_oe` is 1 exactly when both `mux_en` and `clk_mode` were high at the previous clock edge. If only one of them is set, `sel_oe` stays 0.
- R2: While `sel_oe` is 0, `sel_out` is 0, and no pulse appears on the pin.
- R3: Each active phase lasts exactly two strobe periods.
- R4: The pulse repeats every thirteen strobe periods. The inactive phase therefore lasts eleven strobe periods.
- R5: The pin level during the active phase equals `sel_pol`. During the inactive phase the pin is at the opposite level. A change of `sel_pol` takes effect on the pin in the same cycle.
- R6: While the pulse is inactive, `stat_pri[i]` follows the synchronised `det_pin[i]` and `stat_alt[i]` keeps its value.
- R7: While the pulse is active, `stat_alt[i]` follows the synchronised `det_pin[i]` and `stat_pri[i]` keeps the value it had when the pulse began.
- R8: When the mode turns on, the cycle restarts at the beginning of an active phase. The pulse is active from the first cycle in which `sel_oe` is 1.
- R9: When the mode turns off, every primary bit returns to pass-through and every alternate bit keeps its last value.
- R10: Each detect pin passes through a two-flop synchroniser. A change driven before clock edge k shows on `stat_pri` after edge k+2 and not before.
- R11: The steering depends only on the internal pulse phase. With `sel_pol` at 0, the primary and alternate bits split the input exactly as they do with `sel_pol` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | 64 kHz strobe, high for one clock cycle |
| mux_en | input | 1 | Multiplex mode enable |
| clk_mode | input | 1 | Clock-source qualifier; must be 1 for the shared pin to be an output |
| sel_pol | input | 1 | Pin level during the active phase (1 = active high) |
| det_pin | input | 8 | Raw asynchronous detect inputs, one per channel |
| sel_out | output | 1 | Select pulse level for the shared pin |
| sel_oe | output | 1 | Output-enable for the shared pin |
| stat_pri | output | 8 | Primary status bits, fed while the pulse is inactive |
| stat_alt | output | 8 | Alternate status bits, fed while the pulse is active |

## Verification
The hardest situation to reach is a detect change that arrives strictly inside the two-period active window, settles into the alternate bit, and does not leak into the primary bit across either edge of the window. The bench first waits for an active-to-inactive transition, which places it at the start of a long inactive phase. It then waits for the next rising phase and drives the new value one cycle into the window, so the synchroniser delay ends well before the window closes. The same sequence is repeated with inverted polarity. A further pass turns the mode off in the middle of an active window to show that the alternate bits are held.

// File: rtl/dmx_pkg.sv
// Shared sizing for the detect demultiplexer.
// Assumes one strobe per 64 kHz period; the timing counts are in strobe periods.
package dmx_pkg;
    localparam int unsigned DMX_CHANNELS    = 8;
    localparam int unsigned DMX_PERIOD      = 13;
    localparam int unsigned DMX_ACTIVE      = 2;
    localparam int unsigned DMX_SYNC_STAGES = 2;
endpackage

// File: rtl/dmx_sync.sv
// Per-channel multi-flop synchroniser for the asynchronous detect pins.
// Assumes STAGES >= 2. The output is STAGES clock edges behind the pin.
module dmx_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    for (genvar ch = 0; ch < WIDTH; ch++) begin : g_ch
        logic [STAGES-1:0] chain;

        // Shift the pin through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d_async[ch]};
        end

        assign d_sync[ch] = chain[STAGES-1];
    end
endmodule

// File: rtl/dmx_pulse_gen.sv
// Free-running phase counter that produces the select pulse.
// Assumes tick is high for one clock per strobe period. While the mode is off,
// the counter rests at zero, so enabling the mode starts in the active phase.
module dmx_pulse_gen #(
    parameter int unsigned PERIOD = 13,
    parameter int unsigned ACTIVE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic mode_req,
    output logic mode_on,
    output logic pulse_act
);
    localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
    localparam logic [CW-1:0] ACT  = CW'(ACTIVE);

    logic [CW-1:0] phase;

    // Register the mode request and advance the phase on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_on <= 1'b0;
            phase   <= '0;
        end else begin
            mode_on <= mode_req;
            if (!mode_on)  phase <= '0;
            else if (tick) phase <= (phase == LAST) ? '0 : phase + 1'b1;
        end
    end

    assign pulse_act = mode_on && (phase < ACT);
endmodule

// File: rtl/dmx_steer.sv
// Splits each synchronised detect bit into a primary and an alternate bit.
// Flops with an enable stand in for the transparent latches. The internal,
// uninverted pulse selects which of the two bits is loaded.
module dmx_steer #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_act,
    input  logic [WIDTH-1:0] det_s,
    output logic [WIDTH-1:0] pri,
    output logic [WIDTH-1:0] alt
);
    for (genvar ch = 0; ch < WIDTH; ch++) begin : g_ch
        // Load the primary bit outside the pulse and the alternate bit inside it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pri[ch] <= 1'b0;
                alt[ch] <= 1'b0;
            end else if (pulse_act) begin
                alt[ch] <= det_s[ch];
            end else begin
                pri[ch] <= det_s[ch];
            end
        end
    end
endmodule

// File: rtl/dmx_detect_split.sv
// Top level: select pulse generator plus detect demultiplexer for N channels.
// Assumes tick is synchronous to clk. The polarity is applied at the pin only.
module dmx_detect_split
    import dmx_pkg::*;
#(
    parameter int unsigned CHANNELS    = DMX_CHANNELS,
    parameter int unsigned PERIOD      = DMX_PERIOD,
    parameter int unsigned ACTIVE      = DMX_ACTIVE,
    parameter int unsigned SYNC_STAGES = DMX_SYNC_STAGES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                mux_en,
    input  logic                clk_mode,
    input  logic                sel_pol,
    input  logic [CHANNELS-1:0] det_pin,
    output logic                sel_out,
    output logic                sel_oe,
    output logic [CHANNELS-1:0] stat_pri,
    output logic [CHANNELS-1:0] stat_alt
);
    logic                mode_on;
    logic                pulse_act;
    logic [CHANNELS-1:0] det_s;

    dmx_pulse_gen #(.PERIOD(PERIOD), .ACTIVE(ACTIVE)) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode_req (mux_en & clk_mode),
        .mode_on  (mode_on),
        .pulse_act(pulse_act)
    );

    dmx_sync #(.WIDTH(CHANNELS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(det_pin),
        .d_sync (det_s)
    );

    dmx_steer #(.WIDTH(CHANNELS)) u_steer (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse_act(pulse_act),
        .det_s    (det_s),
        .pri      (stat_pri),
        .alt      (stat_alt)
    );

    // Drive the pin only in mode; the polarity picks the active level.
    assign sel_oe  = mode_on;
    assign sel_out = mode_on & (pulse_act ~^ sel_pol);
endmodule

// File: rtl/dmx_detect_split_chk.sv
// Property checker for dmx_detect_split, attached by bind.
// Counts strobes inside each active phase to bound its length without deep $past.
module dmx_detect_split_chk #(
    parameter int unsigned CHANNELS = 8,
    parameter int unsigned ACTIVE   = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick,
    input logic                mux_en,
    input logic                clk_mode,
    input logic                sel_out,
    input logic                sel_oe,
    input logic                pulse_act,
    input logic [CHANNELS-1:0] det_s,
    input logic [CHANNELS-1:0] stat_pri,
    input logic [CHANNELS-1:0] stat_alt
);
    logic [7:0] act_ticks;

    // Count strobes seen while the pulse is active.
    always_ff @(posedge clk) begin
        if (!rst_n || !pulse_act) act_ticks <= '0;
        else if (tick)            act_ticks <= act_ticks + 1'b1;
    end

    p_oe_needs_both_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(mux_en && clk_mode) |=> !sel_oe);

    p_quiet_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_oe |-> !sel_out);

    p_active_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_act |-> (act_ticks < 8'(ACTIVE)));

    p_alt_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_act |=> $stable(stat_alt));

    p_pri_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_act |=> (stat_pri == $past(det_s)));

    p_pri_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_act |=> $stable(stat_pri));

    p_alt_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_act |=> (stat_alt == $past(det_s)));

    p_start_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_oe) |-> pulse_act);
endmodule

bind dmx_detect_split dmx_detect_split_chk #(
    .CHANNELS(CHANNELS),
    .ACTIVE  (ACTIVE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .mux_en   (mux_en),
    .clk_mode (clk_mode),
    .sel_out  (sel_out),
    .sel_oe   (sel_oe),
    .pulse_act(pulse_act),
    .det_s    (det_s),
    .stat_pri (stat_pri),
    .stat_alt (stat_alt)
);

// File: tb/sim_dmx_detect_split.sv
// Directed bench for dmx_detect_split: one task per scenario.
module sim_dmx_detect_split;
    localparam int TICK_DIV = 20;
    localparam int PERIOD   = 13;
    localparam int ACTIVE   = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       mux_en = 1'b0;
    logic       clk_mode = 1'b0;
    logic       sel_pol = 1'b1;
    logic [7:0] det_pin = 8'h00;
    logic       sel_out, sel_oe;
    logic [7:0] stat_pri, stat_alt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int tdiv   = 0;

    dmx_detect_split u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mux_en(mux_en),
        .clk_mode(clk_mode), .sel_pol(sel_pol), .det_pin(det_pin),
        .sel_out(sel_out), .sel_oe(sel_oe),
        .stat_pri(stat_pri), .stat_alt(stat_alt)
    );

    always #2ns clk = ~clk;

    // Strobe generator driven away from the active edge.
    always @(negedge clk) begin
        tdiv <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        tick <= (tdiv == TICK_DIV - 1);
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit pulse_seen();
        return sel_oe && (sel_out == sel_pol);
    endfunction

    task automatic wait_phase(input bit want);
        for (int i = 0; i < 2000; i++) begin
            if (pulse_seen() == want) return;
            step(1);
        end
        chk("R4 phase wait", 32'(pulse_seen()), 32'(want));
    endtask

    task automatic t_reset();
        chk("R2 reset oe", 32'(sel_oe), 0);
        chk("R2 reset pin", 32'(sel_out), 0);
        chk("R6 reset pri", 32'(stat_pri), 0);
        chk("R6 reset alt", 32'(stat_alt), 0);
    endtask

    task automatic t_disabled();
        mux_en = 1'b1; clk_mode = 1'b0; det_pin = 8'h5A;
        step(4);
        chk("R1 enable only", 32'(sel_oe), 0);
        chk("R2 pin quiet", 32'(sel_out), 0);
        chk("R6 pri pass", 32'(stat_pri), 32'h5A);
        chk("R6 alt held", 32'(stat_alt), 0);
        mux_en = 1'b0; clk_mode = 1'b1;
        step(3);
        chk("R1 clkmode only", 32'(sel_oe), 0);
    endtask

    task automatic t_sync_latency();
        det_pin = 8'hC3;
        step(2);
        chk("R10 not yet", 32'(stat_pri), 32'h5A);
        step(1);
        chk("R10 arrived", 32'(stat_pri), 32'hC3);
    endtask

    task automatic t_enable();
        sel_pol = 1'b1; mux_en = 1'b1; clk_mode = 1'b1;
        step(1);
        chk("R1 oe on", 32'(sel_oe), 1);
        chk("R8 starts active", 32'(sel_out), 1);
    endtask

    task automatic t_timing();
        int n_act = 0;
        int n_idle = 0;
        wait_phase(1'b0);
        wait_phase(1'b1);
        while (pulse_seen() && n_act < 1000) begin n_act++; step(1); end
        while (!pulse_seen() && n_idle < 1000) begin n_idle++; step(1); end
        chk("R3 active length", 32'(n_act), 32'(ACTIVE * TICK_DIV));
        chk("R4 idle length", 32'(n_idle), 32'((PERIOD - ACTIVE) * TICK_DIV));
    endtask

    task automatic t_polarity();
        wait_phase(1'b0);
        wait_phase(1'b1);
        step(2);
        chk("R5 high active", 32'(sel_out), 1);
        sel_pol = 1'b0;
        #0.5ns;
        chk("R5 low active", 32'(sel_out), 0);
        wait_phase(1'b0);
        step(1);
        chk("R5 low idle", 32'(sel_out), 1);
    endtask

    task automatic t_steer(input logic pol, input logic [7:0] a, input logic [7:0] b, input string req);
        logic [7:0] alt0;
        sel_pol = pol;
        wait_phase(1'b1);
        wait_phase(1'b0);
        alt0 = stat_alt;
        step(1);
        det_pin = a;
        step(4);
        chk({"R6 pri idle ", req}, 32'(stat_pri), 32'(a));
        chk({"R6 alt idle ", req}, 32'(stat_alt), 32'(alt0));
        wait_phase(1'b1);
        step(1);
        det_pin = b;
        step(4);
        chk({"R7 alt active ", req}, 32'(stat_alt), 32'(b));
        chk({"R7 pri hold ", req}, 32'(stat_pri), 32'(a));
        wait_phase(1'b0);
        step(4);
        chk({"R6 pri after ", req}, 32'(stat_pri), 32'(b));
        chk({"R6 alt keep ", req}, 32'(stat_alt), 32'(b));
    endtask

    task automatic t_disable();
        logic [7:0] alt0;
        sel_pol = 1'b1;
        wait_phase(1'b0);
        wait_phase(1'b1);
        step(1);
        alt0 = stat_alt;
        mux_en = 1'b0;
        step(1);
        chk("R9 oe off", 32'(sel_oe), 0);
        chk("R2 pin off", 32'(sel_out), 0);
        det_pin = 8'h96;
        step(4);
        chk("R9 pri pass", 32'(stat_pri), 32'h96);
        chk("R9 alt held", 32'(stat_alt), 32'(alt0));
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_disabled();
        t_sync_latency();
        t_enable();
        t_timing();
        t_polarity();
        t_steer(1'b1, 8'hA5, 8'h3C, "pol1");
        t_steer(1'b0, 8'h0F, 8'hE1, "pol0 R11");
        t_disable();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule